// File: doc/BRIEF.md
# Interrupt context save sequencer

When an interrupt request is accepted, this block writes the processor context to the stack through a 16-bit data-memory write port. The context is a 20-bit program counter and a 16-bit flag register. One bit of the flag register selects which of two stack pointers is used, and the block returns that pointer's new value when it finishes.

The stacked image always takes four bytes directly below the starting pointer. The first byte below the pointer is shared: its upper nibble holds the top four flag bits and its lower nibble holds the top four program-counter bits. The next byte down holds the low flag byte. The two bytes below that hold the middle and low program-counter bytes.

The number of memory operations depends on the alignment of the starting pointer. An even pointer takes two full-width writes. An odd pointer takes four single-byte writes. Each operation waits for the memory to signal ready.

Top module: `irq_ctx_push`

## Requirements
- R1: The starting pointer is `usp_in` when `flg_in[SEL_BIT]` (default bit 7) is 1, and `isp_in` when that bit is 0. `sp_user` reports the choice together with `done`.
- R2: For an even starting pointer SP, exactly two writes are issued. Both have `mem_be`=2'b11. The first goes to SP−2 and the second to SP−4.
- R3: For an odd starting pointer SP, exactly four writes are issued to SP−1, SP−2, SP−3 and SP−4, in that order. Each write enables one lane only. `mem_be`=2'b10 (data in `mem_wdata[15:8]`) is used when the address is odd, and 2'b01 (data in `mem_wdata[7:0]`) when it is even.
- R4: After the push, memory holds the following bytes. At SP−1: {flg[15:12], pc[19:16]}. At SP−2: flg[7:0]. At SP−3: pc[15:8]. At SP−4: pc[7:0]. A full-width write puts its low byte at the even address.
- R5: `sp_out` equals SP−4 modulo 2^16 when `done` is high. The write addresses wrap modulo 2^16 in the same way.
- R6: A write is accepted only on a clock edge where `mem_we` and `mem_rdy` are both high. While `mem_rdy` is low, the address, data and byte enables stay unchanged.
- R7: `busy` rises on the cycle after `req` is accepted. It falls on the edge that accepts the last write. On that same edge `done` rises, and `done` stays high for exactly one cycle.
- R8: A `req` that arrives while `busy` is high is ignored. It causes no extra writes and does not change the image or the final pointer.
- R9: Under reset, `busy`, `done` and `mem_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Interrupt accepted; start a push when idle |
| pc_in | input | PC_W (20) | Program counter to save |
| flg_in | input | FLG_W (16) | Flag register to save; bit SEL_BIT selects the stack |
| isp_in | input | AW (16) | Stack pointer used when the select bit is 0 |
| usp_in | input | AW (16) | Stack pointer used when the select bit is 1 |
| mem_rdy | input | 1 | Memory takes the current write on this edge |
| mem_we | output | 1 | Write request |
| mem_addr | output | AW (16) | Byte address of the write |
| mem_wdata | output | 16 | Write data, two byte lanes |
| mem_be | output | 2 | Byte-lane enables |
| busy | output | 1 | Push in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | AW (16) | Updated stack pointer |
| sp_user | output | 1 | The updated pointer belongs to the select=1 stack |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of a push. A fast memory ends a push within two or four cycles, which leaves almost no time to inject one. The bench therefore holds `mem_rdy` low to freeze the sequencer after its first write has been presented. It then drives a conflicting request with a different pointer and releases the memory. Finally it checks that the image, the operation count and the returned pointer all follow the first request only. Running with ready held low also exercises the hold rule. A ready signal that toggles every cycle interleaves stalls with accepted writes, and pointers of 0 and 1 exercise the wrap below address zero.

// File: rtl/irq_ctx_push.sv
module irq_ctx_push #(
  parameter int PC_W    = 20,
  parameter int FLG_W   = 16,
  parameter int AW      = 16,
  parameter int SEL_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [FLG_W-1:0] flg_in,
  input  logic [AW-1:0]    isp_in,
  input  logic [AW-1:0]    usp_in,
  input  logic             mem_rdy,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [15:0]      mem_wdata,
  output logic [1:0]       mem_be,
  output logic             busy,
  output logic             done,
  output logic [AW-1:0]    sp_out,
  output logic             sp_user
);
  logic          busy_q, done_q, odd_q, user_q;
  logic [1:0]    step_q;
  logic [AW-1:0] sp_q, sp_out_q, off;
  logic [7:0]    cmb_q, flo_q, pmid_q, plo_q, byte_sel;

  wire unused_flg_mid = ^flg_in[FLG_W-5:8];

  wire           accept = req && !busy_q;
  wire [AW-1:0]  sp_sel = flg_in[SEL_BIT] ? usp_in : isp_in;
  wire           fire   = busy_q && mem_rdy;
  wire           last   = odd_q ? (step_q == 2'd3) : (step_q == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      odd_q    <= 1'b0;
      user_q   <= 1'b0;
      step_q   <= '0;
      sp_q     <= '0;
      sp_out_q <= '0;
      cmb_q    <= '0;
      flo_q    <= '0;
      pmid_q   <= '0;
      plo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        sp_q   <= sp_sel;
        odd_q  <= sp_sel[0];
        user_q <= flg_in[SEL_BIT];
        cmb_q  <= {flg_in[FLG_W-1:FLG_W-4], pc_in[PC_W-1:16]};
        flo_q  <= flg_in[7:0];
        pmid_q <= pc_in[15:8];
        plo_q  <= pc_in[7:0];
      end else if (fire) begin
        step_q <= step_q + 2'd1;
        if (last) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          sp_out_q <= sp_q - AW'(4);
        end
      end
    end
  end

  always_comb begin
    case (step_q)
      2'd0:    byte_sel = cmb_q;
      2'd1:    byte_sel = flo_q;
      2'd2:    byte_sel = pmid_q;
      default: byte_sel = plo_q;
    endcase
  end

  assign off       = odd_q ? AW'(step_q) + AW'(1) : (AW'(step_q) << 1) + AW'(2);
  assign mem_addr  = sp_q - off;
  assign mem_we    = busy_q;
  assign mem_wdata = odd_q ? {byte_sel, byte_sel}
                           : (step_q == 2'd0 ? {cmb_q, flo_q} : {pmid_q, plo_q});
  assign mem_be    = odd_q ? (mem_addr[0] ? 2'b10 : 2'b01) : 2'b11;
  assign busy      = busy_q;
  assign done      = done_q;
  assign sp_out    = sp_out_q;
  assign sp_user   = user_q;
endmodule

module irq_ctx_push_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          mem_rdy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic [1:0]    mem_be,
  input logic          busy,
  input logic          done
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !mem_rdy |=> mem_we && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be));

  p_full_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_be == 2'b11 |-> !mem_addr[0]);

  p_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $countones(mem_be) == 1 |-> mem_be[1] == mem_addr[0]);

  p_be_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_be != 2'b00);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_we);

  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req && !busy |=> busy);

  p_stall_keeps_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_rdy |=> busy);
endmodule

bind irq_ctx_push irq_ctx_push_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .mem_rdy(mem_rdy), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .busy(busy), .done(done)
);

// File: tb/sim_irq_ctx_push.sv
`timescale 1ns/1ps
module sim_irq_ctx_push;
  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, mem_rdy = 1'b1;
  logic [19:0] pc_in = '0;
  logic [15:0] flg_in = '0, isp_in = '0, usp_in = '0;
  logic        mem_we, busy, done, sp_user;
  logic [15:0] mem_addr, mem_wdata, sp_out;
  logic [1:0]  mem_be;

  irq_ctx_push u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int ops = 0, done_cnt = 0, bad_be = 0;
  logic [15:0] got_sp;
  logic        got_user;
  logic        stall_mode = 1'b0, force_low = 1'b0;
  logic [7:0]  mem [logic [15:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (rst_n && mem_we && mem_rdy) begin
      ops++;
      if (mem_be[0]) mem[{mem_addr[15:1], 1'b0}] = mem_wdata[7:0];
      if (mem_be[1]) mem[{mem_addr[15:1], 1'b1}] = mem_wdata[15:8];
      if (mem_be == 2'b11 && mem_addr[0]) bad_be++;
      if (mem_be == 2'b01 && mem_addr[0]) bad_be++;
      if (mem_be == 2'b10 && !mem_addr[0]) bad_be++;
      if (mem_be == 2'b00) bad_be++;
    end
    if (rst_n && done) begin
      done_cnt++;
      got_sp   = sp_out;
      got_user = sp_user;
    end
  end

  always @(negedge clk)
    mem_rdy <= force_low ? 1'b0 : (stall_mode ? ~mem_rdy : 1'b1);

  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'hxx;
  endfunction

  task automatic clear_run();
    mem.delete();
    ops = 0; done_cnt = 0; bad_be = 0;
  endtask

  task automatic start(input logic [15:0] sp, input logic [19:0] pc, input logic [15:0] flg);
    @(negedge clk);
    pc_in = pc; flg_in = flg;
    if (flg[7]) begin usp_in = sp; isp_in = sp ^ 16'h0F0F; end
    else        begin isp_in = sp; usp_in = sp ^ 16'h0F0F; end
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_run();
    int t = 0;
    while (done_cnt == 0 && t < 100) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_image(input string tag, input logic [15:0] sp, input logic [19:0] pc,
                             input logic [15:0] flg);
    chk({tag, " R4 byte sp-1"}, {24'h0, rd(sp - 16'd1)}, {24'h0, flg[15:12], pc[19:16]});
    chk({tag, " R4 byte sp-2"}, {24'h0, rd(sp - 16'd2)}, {24'h0, flg[7:0]});
    chk({tag, " R4 byte sp-3"}, {24'h0, rd(sp - 16'd3)}, {24'h0, pc[15:8]});
    chk({tag, " R4 byte sp-4"}, {24'h0, rd(sp - 16'd4)}, {24'h0, pc[7:0]});
    chk({tag, " R5 sp_out"}, {16'h0, got_sp}, {16'h0, sp - 16'd4});
    chk({tag, " R7 one done pulse"}, done_cnt, 1);
    chk({tag, " R2/R3 op count"}, ops, sp[0] ? 4 : 2);
    chk({tag, " R3 lane enables"}, bad_be, 0);
    chk({tag, " R1 stack select"}, {31'h0, got_user}, {31'h0, flg[7]});
  endtask

  // {sp[15:0], pc[19:0], flg[15:0], stall}
  localparam int NV = 6;
  localparam logic [52:0] VEC [NV] = '{
    {16'h1000, 20'hABCDE, 16'h9F3C, 1'b0},
    {16'h1001, 20'h12345, 16'h7A12, 1'b0},
    {16'h2002, 20'hF0F0F, 16'h5080, 1'b1},
    {16'h3003, 20'h0A5A5, 16'hC1FF, 1'b1},
    {16'h0000, 20'h80001, 16'hE000, 1'b0},
    {16'h0001, 20'h7FFFF, 16'h3407, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", {31'h0, busy}, 0);
    chk("R9 done in reset", {31'h0, done}, 0);
    chk("R9 mem_we in reset", {31'h0, mem_we}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] sp;
      logic [19:0] pc;
      logic [15:0] flg;
      {sp, pc, flg, stall_mode} = VEC[i];
      clear_run();
      start(sp, pc, flg);
      chk($sformatf("vec%0d R7 busy after accept", i), {31'h0, busy}, 1);
      finish_run();
      chk($sformatf("vec%0d R7 busy after done", i), {31'h0, busy}, 0);
      check_image($sformatf("vec%0d", i), sp, pc, flg);
    end
    stall_mode = 1'b0;

    // R6: stall with ready low, then R8: conflicting request mid-push
    clear_run();
    force_low = 1'b1;
    start(16'h4000, 20'h55AA3, 16'h2B44);
    repeat (4) @(negedge clk);
    chk("R6 no write while not ready", ops, 0);
    chk("R6 write held", {31'h0, mem_we}, 1);
    chk("R6 address held at sp-2", {16'h0, mem_addr}, {16'h0, 16'h3FFE});
    chk("R6 data held", {16'h0, mem_wdata}, {16'h0, 16'h2544});
    isp_in = 16'h5001; usp_in = 16'h5001;
    pc_in = 20'h11111; flg_in = 16'h0000;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R8 address unchanged by req", {16'h0, mem_addr}, {16'h0, 16'h3FFE});
    force_low = 1'b0;
    finish_run();
    check_image("R8 ignored req", 16'h4000, 20'h55AA3, 16'h2B44);
    chk("R8 no stray writes", {31'h0, mem.exists(16'h5000)}, 0);

    // R9: reset in the middle of a push
    clear_run();
    force_low = 1'b1;
    start(16'h6006, 20'h00001, 16'h0001);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 busy cleared by reset", {31'h0, busy}, 0);
    chk("R9 mem_we cleared by reset", {31'h0, mem_we}, 0);
    force_low = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 no done after reset", done_cnt, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule